// File: doc/BRIEF.md
# Rolling Activation Window Limiter

This block caps how many row activations a DRAM rank may see inside any rolling window of a fixed number of cycles. It keeps the times of the most recent activations in a short history. Each time the access path reports a completed open-page access that missed the open row, the block works out when the matching activation took place and adds that time to the history. It then compares the new time against the oldest time it still holds.

When the newest group of recorded activations fits inside the window, the block computes the earliest cycle at which another activation may be issued: the oldest held time plus the window length. It holds this bound as a register that can only rise. It applies the bound to the free time of every bank, so each bank reports the later of its own free time and the bound. If an activation arrives that already breaks the limit against the history as it stood before the insert, the block raises a one-cycle violation pulse.

The limit count, the window length, the column and row-to-column delays, the timestamp width and the number of banks are all parameters. The command scheduler, the bank state machines and refresh sit outside this block.

Top module: `act_window_limiter`

## Requirements
- R1: After reset every history slot is zero, `block_until_o` is 0, `violation_o` is 0 and `act_allowed_o` is 1.
- R2: An access with `acc_valid_i`=1 and `acc_row_miss_i`=1 records one activation at time `acc_done_i - T_CL - T_RCD`. The history shifts by one slot, the new time enters the newest slot and the time in the oldest slot is dropped.
- R3: An access with `acc_row_miss_i`=0, or a cycle with `acc_valid_i`=0, records nothing. The history, `block_until_o` and `violation_o` are left as if that cycle had not occurred.
- R4: `violation_o` is 1 in the cycle after a record when the oldest slot held before the insert is non-zero and the new time minus that slot is less than `WINDOW`.
- R5: Take the oldest slot after the insert. If it is non-zero and the new time minus it is less than `WINDOW`, then one cycle after the record `block_until_o` becomes the larger of its previous value and that slot plus `WINDOW`. Otherwise `block_until_o` keeps its value, and it never decreases.
- R6: A slot holding zero counts as unused. With `ACT_LIMIT`=4, the first three activations after reset never move the bound, and the first four never flag a violation.
- R7: For each bank i, the field `bank_free_o[i*TS_W +: TS_W]` equals the larger of `bank_free_i[i*TS_W +: TS_W]` and `block_until_o`.
- R8: `act_allowed_o` is 1 exactly when `now_i >= block_until_o`.
- R9: `violation_o` lasts one cycle. It is 0 in any cycle that does not follow a recorded activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_i | input | TS_W | Free-running current cycle count |
| acc_valid_i | input | 1 | An open-page access completed this cycle |
| acc_row_miss_i | input | 1 | That access needed a new row to be opened |
| acc_done_i | input | TS_W | Completion time of that access |
| bank_free_i | input | N_BANK*TS_W | Free time of each bank, bank i in field i |
| block_until_o | output | TS_W | Earliest cycle at which an activation is allowed |
| act_allowed_o | output | 1 | The current cycle is at or past the bound |
| violation_o | output | 1 | The last recorded activation broke the window |
| bank_free_o | output | N_BANK*TS_W | Each bank's free time raised to the bound |

## Verification
Several properties are checked on every cycle. The newest slot takes the derived activation time after each record, and the history holds still on cycles that record nothing. The bound never falls, a violation pulse always follows a row-miss access, and each clamped bank time is at least both of its inputs. Only the bench scenarios show the exact arithmetic. They cover where the bound lands, the window boundary where a difference of exactly `WINDOW` no longer counts, how zero slots are treated while the history fills, and whether a row hit leaves later decisions untouched. To do this the bench sweeps evenly spaced activation trains and a few irregular ones against its own model.

// File: rtl/act_window_pkg.sv
package act_window_pkg;
  // Outcome of one window evaluation
  typedef struct packed {
    logic early;  // new activate already breaks the window against prior history
    logic clamp;  // after insert, the next activate must wait for the bound
  } win_flags_t;
endpackage

// File: rtl/act_capture.sv
// Turns a completed open-page access into an activate-record strobe.
module act_capture #(
  parameter int TS_W  = 16,
  parameter int T_CL  = 3,
  parameter int T_RCD = 3
) (
  input  logic            acc_valid_i,
  input  logic            acc_row_miss_i,
  input  logic [TS_W-1:0] acc_done_i,
  output logic            rec_o,
  output logic [TS_W-1:0] rec_time_o
);
  localparam logic [TS_W-1:0] LEAD = TS_W'(T_CL + T_RCD);

  function automatic logic [TS_W-1:0] act_stamp(input logic [TS_W-1:0] done);
    return done - LEAD;
  endfunction

  assign rec_o      = acc_valid_i & acc_row_miss_i;
  assign rec_time_o = act_stamp(acc_done_i);
endmodule

// File: rtl/act_history.sv
// Shift register of the most recent activate times, slot 0 newest.
module act_history #(
  parameter int DEPTH = 4,
  parameter int TS_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rec_i,
  input  logic [TS_W-1:0] rec_time_i,
  output logic [TS_W-1:0] oldest_pre_o,
  output logic [TS_W-1:0] oldest_post_o
);
  logic [TS_W-1:0] slot_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TS_W-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (rec_i) q <= rec_time_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (rec_i) q <= slot_w[i-1];
      end
    end
    assign slot_w[i] = q;
  end

  assign oldest_pre_o = slot_w[DEPTH-1];

  if (DEPTH == 1) begin : g_post_single
    assign oldest_post_o = rec_time_i;
  end else begin : g_post_multi
    assign oldest_post_o = slot_w[DEPTH-2];
  end

  // R2: newest slot takes the recorded time
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_i |=> slot_w[0] == $past(rec_time_i));
  // R3: no record, no movement in the history
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_i |=> ($stable(slot_w[0]) && $stable(slot_w[DEPTH-1])));
endmodule

// File: rtl/act_window_eval.sv
// Window arithmetic for one record: early-violation test and block bound.
module act_window_eval
  import act_window_pkg::*;
#(
  parameter int TS_W   = 16,
  parameter int WINDOW = 20
) (
  input  logic [TS_W-1:0] rec_time_i,
  input  logic [TS_W-1:0] oldest_pre_i,
  input  logic [TS_W-1:0] oldest_post_i,
  output win_flags_t      flags_o,
  output logic [TS_W-1:0] bound_o
);
  localparam logic [TS_W-1:0] WIN = TS_W'(WINDOW);

  function automatic logic inside_window(input logic [TS_W-1:0] t,
                                         input logic [TS_W-1:0] old);
    logic [TS_W-1:0] span;
    span = t - old;
    return (old != '0) && (span < WIN);
  endfunction

  assign flags_o.early = inside_window(rec_time_i, oldest_pre_i);
  assign flags_o.clamp = inside_window(rec_time_i, oldest_post_i);
  assign bound_o       = oldest_post_i + WIN;
endmodule

// File: rtl/act_bank_clamp.sv
// Raises each bank's free time to the shared bound.
module act_bank_clamp #(
  parameter int TS_W   = 16,
  parameter int N_BANK = 4
) (
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        bound_i,
  input  logic [N_BANK*TS_W-1:0] free_i,
  output logic [N_BANK*TS_W-1:0] free_o
);
  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic [TS_W-1:0] own;
    logic [TS_W-1:0] out;
    assign own = free_i[b*TS_W +: TS_W];
    assign out = (own > bound_i) ? own : bound_i;
    assign free_o[b*TS_W +: TS_W] = out;

    // R7: clamped time is no earlier than either input
    always_comb begin
      if (rst_n) begin
        p_floor_r7: assert (out >= own && out >= bound_i);
      end
    end
  end
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter
  import act_window_pkg::*;
#(
  parameter int ACT_LIMIT = 4,
  parameter int WINDOW    = 20,
  parameter int TS_W      = 16,
  parameter int T_CL      = 3,
  parameter int T_RCD     = 3,
  parameter int N_BANK    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        now_i,
  input  logic                   acc_valid_i,
  input  logic                   acc_row_miss_i,
  input  logic [TS_W-1:0]        acc_done_i,
  input  logic [N_BANK*TS_W-1:0] bank_free_i,
  output logic [TS_W-1:0]        block_until_o,
  output logic                   act_allowed_o,
  output logic                   violation_o,
  output logic [N_BANK*TS_W-1:0] bank_free_o
);
  // Named internal events
  logic            rec_w;
  logic [TS_W-1:0] rec_time_w;
  logic [TS_W-1:0] oldest_pre_w;
  logic [TS_W-1:0] oldest_post_w;
  logic [TS_W-1:0] bound_w;
  win_flags_t      flags_w;
  logic            raise_w;

  logic [TS_W-1:0] block_q;
  logic            viol_q;

  act_capture #(.TS_W(TS_W), .T_CL(T_CL), .T_RCD(T_RCD)) u_capture (
    .acc_valid_i    (acc_valid_i),
    .acc_row_miss_i (acc_row_miss_i),
    .acc_done_i     (acc_done_i),
    .rec_o          (rec_w),
    .rec_time_o     (rec_time_w)
  );

  act_history #(.DEPTH(ACT_LIMIT), .TS_W(TS_W)) u_history (
    .clk           (clk),
    .rst_n         (rst_n),
    .rec_i         (rec_w),
    .rec_time_i    (rec_time_w),
    .oldest_pre_o  (oldest_pre_w),
    .oldest_post_o (oldest_post_w)
  );

  act_window_eval #(.TS_W(TS_W), .WINDOW(WINDOW)) u_eval (
    .rec_time_i    (rec_time_w),
    .oldest_pre_i  (oldest_pre_w),
    .oldest_post_i (oldest_post_w),
    .flags_o       (flags_w),
    .bound_o       (bound_w)
  );

  assign raise_w = rec_w && flags_w.clamp && (bound_w > block_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      block_q <= '0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= rec_w && flags_w.early;
      if (raise_w) block_q <= bound_w;
    end
  end

  act_bank_clamp #(.TS_W(TS_W), .N_BANK(N_BANK)) u_clamp (
    .rst_n   (rst_n),
    .bound_i (block_q),
    .free_i  (bank_free_i),
    .free_o  (bank_free_o)
  );

  assign block_until_o = block_q;
  assign violation_o   = viol_q;
  assign act_allowed_o = (now_i >= block_q);

  // R5: bound only moves upward
  p_block_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> block_q >= $past(block_q));
  // R4 / R9: a violation pulse always follows a row-miss access
  p_viol_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    violation_o |-> $past(acc_valid_i && acc_row_miss_i));
  // R3: a row hit never moves the bound
  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_row_miss_i) |=> $stable(block_q) && !violation_o);
endmodule

// File: tb/act_window_limiter_tb.sv
`timescale 1ns/1ps
module act_window_limiter_tb;
  localparam int X   = 4;
  localparam int W   = 20;
  localparam int TW  = 16;
  localparam int LD  = 6;   // tCL + tRCD
  localparam int NB  = 4;

  logic clk = 0;
  logic rst_n;
  logic [TW-1:0] now_i;
  logic acc_valid_i, acc_row_miss_i;
  logic [TW-1:0] acc_done_i;
  logic [NB*TW-1:0] bank_free_i;
  logic [TW-1:0] block_until_o;
  logic act_allowed_o, violation_o;
  logic [NB*TW-1:0] bank_free_o;

  always #2 clk = ~clk;

  act_window_limiter #(.ACT_LIMIT(X), .WINDOW(W), .TS_W(TW), .T_CL(3),
                       .T_RCD(3), .N_BANK(NB)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mh [X];
  int mblock;
  int mviol;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      report();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; acc_valid_i = 0; acc_row_miss_i = 0; acc_done_i = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < X; i++) mh[i] = 0;
    mblock = 0; mviol = 0;
  endtask

  // Model: record one activate at time t
  task automatic model_rec(input int t);
    mviol = (mh[X-1] != 0 && t - mh[X-1] < W) ? 1 : 0;
    for (int i = X-1; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = t;
    if (mh[X-1] != 0 && t - mh[X-1] < W && mh[X-1] + W > mblock)
      mblock = mh[X-1] + W;
  endtask

  task automatic access(input int done, input logic miss);
    @(negedge clk);
    acc_valid_i = 1; acc_row_miss_i = miss; acc_done_i = TW'(done);
    @(posedge clk);
    @(negedge clk);
    acc_valid_i = 0;
    if (miss) model_rec(done - LD); else mviol = 0;
    chk(miss ? "R4 violation" : "R3 hit violation", int'(violation_o), mviol);
    chk(miss ? "R5 block_until" : "R3 hit block_until", int'(block_until_o), mblock);
  endtask

  task automatic check_idle_pulse();
    @(negedge clk);
    chk("R9 pulse cleared", int'(violation_o), 0);
  endtask

  task automatic check_allow_and_clamp();
    int b;
    b = int'(block_until_o);
    now_i = TW'(b > 0 ? b - 1 : 0); #1;
    chk("R8 allowed below bound", int'(act_allowed_o), (b > 0) ? 0 : 1);
    now_i = TW'(b); #1;
    chk("R8 allowed at bound", int'(act_allowed_o), 1);
    now_i = TW'(b + 1); #1;
    chk("R8 allowed past bound", int'(act_allowed_o), 1);
    bank_free_i = {TW'(0), TW'(b + 7), TW'(b), TW'(b > 5 ? b - 5 : 0)};
    #1;
    chk("R7 bank0", int'(bank_free_o[0 +: TW]), b);
    chk("R7 bank1", int'(bank_free_o[TW +: TW]), b);
    chk("R7 bank2", int'(bank_free_o[2*TW +: TW]), b + 7);
    chk("R7 bank3", int'(bank_free_o[3*TW +: TW]), b);
  endtask

  initial begin
    rst_n = 0; acc_valid_i = 0; acc_row_miss_i = 0; acc_done_i = 0;
    now_i = 0; bank_free_i = '0;
    do_reset();
    // R1 reset state
    chk("R1 block_until", int'(block_until_o), 0);
    chk("R1 violation", int'(violation_o), 0);
    chk("R1 allowed", int'(act_allowed_o), 1);

    // Sweep of evenly spaced trains; R2 and R6 are exercised via the model
    for (int g = 1; g <= 12; g++) begin
      do_reset();
      for (int k = 0; k < 6; k++) begin
        access(40 + k*g + LD, 1'b1);
        if (k < 3) chk("R6 no bound while filling", int'(block_until_o), 0);
        if (k < 4) chk("R6 no violation while filling", int'(violation_o), 0);
      end
      check_idle_pulse();
      check_allow_and_clamp();
    end

    // Irregular: span 19 then exactly 20 (R5 and R4 boundaries)
    do_reset();
    access(100 + LD, 1); access(105 + LD, 1); access(110 + LD, 1);
    access(119 + LD, 1);
    chk("R5 span 19 bound", int'(block_until_o), 120);
    access(120 + LD, 1);
    chk("R4 span exactly 20 no violation", int'(violation_o), 0);
    chk("R5 bound rises to 125", int'(block_until_o), 125);
    check_allow_and_clamp();

    // Span exactly 20 does not clamp
    do_reset();
    access(200 + LD, 1); access(207 + LD, 1); access(214 + LD, 1);
    access(220 + LD, 1);
    chk("R5 span 20 no bound", int'(block_until_o), 0);

    // R3: row hits and idle cycles leave history untouched
    do_reset();
    access(300 + LD, 1); access(302 + LD, 1); access(304 + LD, 1);
    access(306 + LD, 1);
    access(307 + LD, 0);
    access(308 + LD, 0);
    access(309 + LD, 1);   // model: pre-oldest 300 -> violation, post-oldest 302
    chk("R3 later miss after hits block", int'(block_until_o), 322);
    repeat (3) @(negedge clk);
    chk("R3 idle keeps bound", int'(block_until_o), 322);
    chk("R9 idle no violation", int'(violation_o), 0);
    access(400 + LD, 1);   // pre-oldest 302: 98 >= W
    chk("R2 history shifted: far activate no violation", int'(violation_o), 0);
    chk("R5 far activate keeps bound", int'(block_until_o), 322);

    report();
  end
endmodule